// File: doc/BRIEF.md
# Raster Timing Generator with Write-Protected Registers

This block produces the raster timing for a display. A horizontal pixel counter and a vertical line counter run on the pixel clock. Programmable windows on those counts drive a composite blank output, a horizontal and a vertical sync, and a second sync pair meant for a flat panel. Software programs the geometry through a word-wide register port. Every register except the lock register ignores writes until a specific key has been written to the lock register.

Each timing register holds two 16-bit fields, and each field stores its count minus one. The frame runs in this order: visible region, front porch, sync pulse, back porch. Blanking covers everything after the visible region up to the end of the line or frame. The panel vertical sync register stores its window minus two, so the panel vsync pulse leads the main vsync by one line. A control register turns the counters, blanking, the two main syncs and the panel pair on and off independently.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the block is locked, every stored register reads 0, both counters are 0, all four sync outputs are low and blank is high.
- R2: A write to address 0 unlocks the block when the data equals 32'h4758 and locks it for any other value, including 0. A read of address 0 returns 1 while unlocked and 0 while locked.
- R3: While the block is locked, writes to addresses 1 to 9 leave the stored values unchanged.
- R4: The register addresses are: 1 h active/total, 2 h blank start/end, 3 h sync start/end, 4 v active/total, 5 v blank start/end, 6 v sync start/end, 7 panel h sync start/end, 8 panel v sync start/end, and 9 control. Each pair keeps its first value in bits 15:0 and its second value in bits 31:16. While unlocked, a register reads back the last value written to it.
- R5: While running, the horizontal count advances by one each clock from 0 up to the stored h total (bits 31:16 of address 1), and then returns to 0.
- R6: The vertical count advances by one on each horizontal wrap. It returns to 0 after the wrap on which it equals the stored v total (bits 31:16 of address 4).
- R7: With blanking enabled (control bit 1), blank is high when the h count is greater than the h blank start and no greater than the h blank end, or when the v count meets the same test against the v blank fields.
- R8: hsync is high when control bits 0 and 2 are set and the h count is greater than the h sync start and no greater than the h sync end. vsync uses control bit 3 and the v sync fields in the same way.
- R9: panel_hsync and panel_vsync apply the same window test to registers 7 and 8 and are gated by control bits 0 and 4. With the panel v sync register programmed two below the true sync start and end, panel_vsync covers the line before the vsync line.
- R10: While control bit 0 (generator enable) is clear, all sync outputs are low and blank is high at once, and both counters read 0 from the next clock on.
- R11: While the generator runs with control bit 1 clear, blank stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| h_count | output | 16 | Current horizontal count |
| v_count | output | 16 | Current vertical count |
| blank | output | 1 | Display blank, high = blanked |
| hsync | output | 1 | Main horizontal sync, active high |
| vsync | output | 1 | Main vertical sync, active high |
| panel_hsync | output | 1 | Panel horizontal sync, active high |
| panel_vsync | output | 1 | Panel vertical sync, active high |

## Verification
The hardest condition to reach is the frame-level corner: the horizontal wrap that lands on the last line. At that point the vertical count must return to zero in the same clock, and the panel vsync must lead the main vsync by exactly one line. The stimulus uses a very small geometry of 8 clocks by 6 lines. It enables the generator and scores every cycle of more than two whole frames against a model of the intended visible, porch and sync regions. The generator is disabled between runs so that each run starts from count zero, and the control word is changed to cover blanking-off and partly gated sync settings.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int DTG_DATA_W  = 32;
    localparam int DTG_FIELD_W = 16;
    localparam int DTG_ADDR_W  = 4;
    localparam int DTG_NREG    = 10;
    localparam logic [31:0] DTG_KEY = 32'h0000_4758;

    typedef enum logic [3:0] {
        AD_LOCK   = 4'd0,
        AD_H_AT   = 4'd1,
        AD_H_BLK  = 4'd2,
        AD_H_SYN  = 4'd3,
        AD_V_AT   = 4'd4,
        AD_V_BLK  = 4'd5,
        AD_V_SYN  = 4'd6,
        AD_P_HSYN = 4'd7,
        AD_P_VSYN = 4'd8,
        AD_CTRL   = 4'd9
    } dtg_addr_e;

    localparam int CB_GEN   = 0;
    localparam int CB_BLANK = 1;
    localparam int CB_HSYNC = 2;
    localparam int CB_VSYNC = 3;
    localparam int CB_PANEL = 4;

    localparam int NUM_WIN = 6;
    localparam int W_HBLK  = 0;
    localparam int W_VBLK  = 1;
    localparam int W_HSYN  = 2;
    localparam int W_VSYN  = 3;
    localparam int W_PHSYN = 4;
    localparam int W_PVSYN = 5;
endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile #(
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 4,
    parameter int          NREG   = 10,
    parameter logic [31:0] KEY    = 32'h0000_4758
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NREG-1:1][DATA_W-1:0]  regs,
    output logic                         unlocked
);
    typedef struct packed {
        logic                        open;
        logic [NREG-1:1][DATA_W-1:0] r;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == '0) begin
                st_d.open = (wdata == DATA_W'(KEY));
            end else if (st_q.open && (int'(addr) < NREG)) begin
                st_d.r[addr] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == '0)             rdata = DATA_W'(st_q.open);
        else if (int'(addr) < NREG) rdata = st_q.r[addr];
    end

    assign regs     = st_q.r;
    assign unlocked = st_q.open;
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        wrap    = run && step && (count_q >= last);
        count_d = count_q;
        if (!run)      count_d = '0;
        else if (wrap) count_d = '0;
        else if (step) count_d = count_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/dtg_window.sv
module dtg_window #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    always_comb hit = (cnt > lo) && (cnt <= hi);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int          DATA_W  = DTG_DATA_W,
    parameter int          FIELD_W = DTG_FIELD_W,
    parameter int          ADDR_W  = DTG_ADDR_W,
    parameter int          NREG    = DTG_NREG,
    parameter logic [31:0] KEY     = DTG_KEY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [FIELD_W-1:0] h_count,
    output logic [FIELD_W-1:0] v_count,
    output logic               blank,
    output logic               hsync,
    output logic               vsync,
    output logic               panel_hsync,
    output logic               panel_vsync
);
    localparam int HI = 2 * FIELD_W - 1;

    logic [NREG-1:1][DATA_W-1:0] regs;
    logic                        unlocked;
    logic [DATA_W-1:0]           ctrl_word;
    logic                        gen_en, blank_en, hs_en, vs_en, pnl_en;
    logic [FIELD_W-1:0]          h_last, v_last;
    logic                        h_wrap, v_wrap;
    logic [FIELD_W-1:0]          win_cnt [NUM_WIN];
    logic [FIELD_W-1:0]          win_lo  [NUM_WIN];
    logic [FIELD_W-1:0]          win_hi  [NUM_WIN];
    logic [NUM_WIN-1:0]          win_hit;
    logic                        unused_bits;

    dtg_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG), .KEY(KEY)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .regs(regs), .unlocked(unlocked)
    );

    assign ctrl_word = regs[AD_CTRL];
    assign gen_en    = ctrl_word[CB_GEN];
    assign blank_en  = ctrl_word[CB_BLANK];
    assign hs_en     = ctrl_word[CB_HSYNC];
    assign vs_en     = ctrl_word[CB_VSYNC];
    assign pnl_en    = ctrl_word[CB_PANEL];
    assign h_last    = regs[AD_H_AT][HI:FIELD_W];
    assign v_last    = regs[AD_V_AT][HI:FIELD_W];
    assign unused_bits = ^{ctrl_word[DATA_W-1:CB_PANEL+1], regs[AD_H_AT][FIELD_W-1:0],
                           regs[AD_V_AT][FIELD_W-1:0], v_wrap};

    dtg_axis #(.W(FIELD_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .run(gen_en), .step(1'b1),
        .last(h_last), .count(h_count), .wrap(h_wrap)
    );

    dtg_axis #(.W(FIELD_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .run(gen_en), .step(h_wrap),
        .last(v_last), .count(v_count), .wrap(v_wrap)
    );

    always_comb begin
        win_cnt[W_HBLK]  = h_count; win_lo[W_HBLK]  = regs[AD_H_BLK][FIELD_W-1:0];  win_hi[W_HBLK]  = regs[AD_H_BLK][HI:FIELD_W];
        win_cnt[W_VBLK]  = v_count; win_lo[W_VBLK]  = regs[AD_V_BLK][FIELD_W-1:0];  win_hi[W_VBLK]  = regs[AD_V_BLK][HI:FIELD_W];
        win_cnt[W_HSYN]  = h_count; win_lo[W_HSYN]  = regs[AD_H_SYN][FIELD_W-1:0];  win_hi[W_HSYN]  = regs[AD_H_SYN][HI:FIELD_W];
        win_cnt[W_VSYN]  = v_count; win_lo[W_VSYN]  = regs[AD_V_SYN][FIELD_W-1:0];  win_hi[W_VSYN]  = regs[AD_V_SYN][HI:FIELD_W];
        win_cnt[W_PHSYN] = h_count; win_lo[W_PHSYN] = regs[AD_P_HSYN][FIELD_W-1:0]; win_hi[W_PHSYN] = regs[AD_P_HSYN][HI:FIELD_W];
        win_cnt[W_PVSYN] = v_count; win_lo[W_PVSYN] = regs[AD_P_VSYN][FIELD_W-1:0]; win_hi[W_PVSYN] = regs[AD_P_VSYN][HI:FIELD_W];
    end

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        dtg_window #(.W(FIELD_W)) u_win (
            .cnt(win_cnt[gi]), .lo(win_lo[gi]), .hi(win_hi[gi]), .hit(win_hit[gi])
        );
    end

    always_comb begin
        blank       = !gen_en || !blank_en || win_hit[W_HBLK] || win_hit[W_VBLK];
        hsync       = gen_en && hs_en  && win_hit[W_HSYN];
        vsync       = gen_en && vs_en  && win_hit[W_VSYN];
        panel_hsync = gen_en && pnl_en && win_hit[W_PHSYN];
        panel_vsync = gen_en && pnl_en && win_hit[W_PVSYN];
    end
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int          DATA_W  = 32,
    parameter int          FIELD_W = 16,
    parameter int          ADDR_W  = 4,
    parameter int          NREG    = 10,
    parameter logic [31:0] KEY     = 32'h0000_4758
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_we,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic                         unlocked,
    input logic [(NREG-1)*DATA_W-1:0]   regs_flat,
    input logic                         gen_en,
    input logic [FIELD_W-1:0]           h_last,
    input logic [FIELD_W-1:0]           v_last,
    input logic [FIELD_W-1:0]           h_count,
    input logic [FIELD_W-1:0]           v_count,
    input logic                         blank,
    input logic                         hsync,
    input logic                         vsync,
    input logic                         panel_hsync,
    input logic                         panel_vsync
);
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr != '0 && !unlocked) |=> $stable(regs_flat)); // R3
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && reg_wdata == DATA_W'(KEY)) |=> unlocked); // R2
    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && reg_wdata != DATA_W'(KEY)) |=> !unlocked); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count < h_last) |=> (h_count == $past(h_count) + 1'b1)); // R5
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count >= h_last) |=> (h_count == '0)); // R5
    AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count >= h_last && v_count < v_last) |=> (v_count == $past(v_count) + 1'b1)); // R6
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count < h_last) |=> $stable(v_count)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (h_count == '0 && v_count == '0)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> (blank && !hsync && !vsync && !panel_hsync && !panel_vsync)); // R10
endmodule

bind disp_timing_gen dtg_checker #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .NREG(NREG), .KEY(KEY)
) u_dtg_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .unlocked(unlocked), .regs_flat(regs),
    .gen_en(gen_en), .h_last(h_last), .v_last(v_last),
    .h_count(h_count), .v_count(v_count), .blank(blank), .hsync(hsync),
    .vsync(vsync), .panel_hsync(panel_hsync), .panel_vsync(panel_vsync)
);

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
    localparam int HTOT = 8, HACT = 4, HSS = 5, HSE = 7;
    localparam int VTOT = 6, VACT = 3, VSS = 4, VSE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] h_count, v_count;
    logic        blank, hsync, vsync, panel_hsync, panel_vsync;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [15:0] h;
        logic [15:0] v;
        logic        bl, hs, vs, phs, pvs;
    } obs_t;

    obs_t exp_q[$];

    always #10 clk = ~clk;

    disp_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .h_count(h_count),
        .v_count(v_count), .blank(blank), .hsync(hsync), .vsync(vsync),
        .panel_hsync(panel_hsync), .panel_vsync(panel_vsync)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // Expected outputs k cycles after the generator is switched on from count zero.
    function automatic obs_t model(input int k, input logic [4:0] c);
        obs_t o;
        int h, v;
        h = k % HTOT;
        v = (k / HTOT) % VTOT;
        o.h   = 16'(h);
        o.v   = 16'(v);
        o.bl  = !c[1] || h >= HACT || v >= VACT;
        o.hs  = c[2] && h >= HSS && h < HSE;
        o.vs  = c[3] && v >= VSS && v < VSE;
        o.phs = c[4] && h >= HSS && h < HSE;
        o.pvs = c[4] && v >= VSS - 1 && v < VSE - 1;
        return o;
    endfunction

    // Driver: enable the generator and queue the expected trace.
    task automatic run_trace(input logic [4:0] c, input int n);
        wr(4'd9, {27'd0, c});
        for (int k = 0; k < n; k++) exp_q.push_back(model(k, c));
        while (exp_q.size() != 0) @(posedge clk);
        #2;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                obs_t e, a;
                e = exp_q.pop_front();
                a = '{h: h_count, v: v_count, bl: blank, hs: hsync, vs: vsync,
                      phs: panel_hsync, pvs: panel_vsync};
                if (a.h != e.h)                    chk(0, "R5 h_count", 32'(a.h), 32'(e.h));
                else if (a.v != e.v)               chk(0, "R6 v_count", 32'(a.v), 32'(e.v));
                else if (a.bl != e.bl)             chk(0, "R7 R11 blank", 32'(a.bl), 32'(e.bl));
                else if ({a.hs, a.vs} != {e.hs, e.vs}) chk(0, "R8 sync", 32'({a.hs, a.vs}), 32'({e.hs, e.vs}));
                else if ({a.phs, a.pvs} != {e.phs, e.pvs}) chk(0, "R9 panel sync", 32'({a.phs, a.pvs}), 32'({e.phs, e.pvs}));
                else                               chk(1, "trace", 0, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(h_count == 0 && v_count == 0, "R1 counters", {h_count, v_count}, 0);
        chk({hsync, vsync, panel_hsync, panel_vsync} == 0, "R1 syncs",
            32'({hsync, vsync, panel_hsync, panel_vsync}), 0);
        chk(blank == 1'b1, "R1 blank", 32'(blank), 1);
        rd_chk(4'd0, 32'd0, "R1 R2 lock status");
        rd_chk(4'd9, 32'd0, "R1 ctrl");
        // R3 write while locked
        wr(4'd1, 32'h0007_0003);
        rd_chk(4'd1, 32'd0, "R3 locked write");
        // R2 unlock
        wr(4'd0, 32'h0000_4758);
        rd_chk(4'd0, 32'd1, "R2 unlocked status");
        // R4 program geometry
        wr(4'd1, 32'h0007_0003);
        wr(4'd2, 32'h0007_0003);
        wr(4'd3, 32'h0006_0004);
        wr(4'd4, 32'h0005_0002);
        wr(4'd5, 32'h0005_0002);
        wr(4'd6, 32'h0004_0003);
        wr(4'd7, 32'h0006_0004);
        wr(4'd8, 32'h0003_0002);
        rd_chk(4'd1, 32'h0007_0003, "R4 h active/total readback");
        rd_chk(4'd6, 32'h0004_0003, "R4 v sync readback");
        rd_chk(4'd8, 32'h0003_0002, "R4 panel v sync readback");
        // R5..R9 all enables, over two frames and a bit
        run_trace(5'b11111, 2 * HTOT * VTOT + 5);
        // R10 disable
        wr(4'd9, 32'd0);
        @(negedge clk);
        chk({hsync, vsync, panel_hsync, panel_vsync} == 0, "R10 syncs off",
            32'({hsync, vsync, panel_hsync, panel_vsync}), 0);
        chk(blank == 1'b1, "R10 blank", 32'(blank), 1);
        @(negedge clk);
        chk(h_count == 0 && v_count == 0, "R10 counters held", {h_count, v_count}, 0);
        // R11 blank disabled, hsync disabled, vsync and panel on
        run_trace(5'b11001, HTOT * VTOT + 3);
        wr(4'd9, 32'd0);
        // R8 R9 gating: hsync only, panel off
        run_trace(5'b00111, HTOT * VTOT);
        // R2 R3 relock with zero then attempt writes
        wr(4'd0, 32'd0);
        rd_chk(4'd0, 32'd0, "R2 relocked by zero");
        wr(4'd9, 32'd0);
        rd_chk(4'd9, 32'h0000_0007, "R3 ctrl protected");
        wr(4'd3, 32'hFFFF_FFFF);
        rd_chk(4'd3, 32'h0006_0004, "R3 h sync protected");
        wr(4'd0, 32'h0000_4758);
        wr(4'd0, 32'h0000_1234);
        rd_chk(4'd0, 32'd0, "R2 wrong key locks");
        repeat (2) @(posedge clk);
        report();
    end
endmodule